// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the 32-bit program counter of a processor whose instructions are 32-bit words on word-aligned addresses. On each enabled clock it loads the address of the next instruction. It reads the opcode and function fields of the current instruction word and picks a source for that address. The sources are: the following word, a branch target relative to the following word, a direct jump target inside the current 256 MB region, or a full 32-bit address from a register.

The comparison result used by conditional branches comes from outside the block, as does the register value used by the indirect jump. The block also drives a link address for calls, which is the address of the following instruction. The decoder sorts each instruction into one of six named kinds: `KIND_SEQ`, `KIND_BEQ`, `KIND_BNE`, `KIND_JMP`, `KIND_CALL` and `KIND_JREG`. The select stage maps each kind to a next-address source.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` is loaded with 0x00000000 whatever the other inputs are.
- R2: When `en` is low and `rst` is low, `pc` keeps its value across the clock edge.
- R3: For an instruction that is not a control transfer, `pc` advances by 4. This covers any opcode other than 2, 3, 4 and 5 in bits [31:26], and also opcode 0 when the funct field in bits [5:0] is not 8.
- R4: Opcode 4 (branch if equal) with `cmp_eq` high loads `pc + 4 + (sign-extended bits [15:0] shifted left by 2)`. With `cmp_eq` low it loads `pc + 4`.
- R5: Opcode 5 (branch if not equal) is taken when `cmp_eq` is low, using the same target as R4. When `cmp_eq` is high it loads `pc + 4`.
- R6: A branch offset with bit 15 set counts backwards. An offset of 0xFFFF gives back the branch's own address, and all address arithmetic wraps modulo 2^32.
- R7: Opcode 2 (jump) loads `{pc[31:28], instr[25:0], 2'b00}`, with the top four bits taken from the current `pc`.
- R8: Opcode 3 (jump and link) loads the same target as R7.
- R9: Opcode 0 with funct 8 (register jump) loads all 32 bits of `reg_target`.
- R10: `link_addr` always equals `pc + 4`, including at 0xFFFFFFFC, where it wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction word at the current PC |
| cmp_eq | input | 1 | High when the two compared registers are equal |
| reg_target | input | 32 | Register value for the register jump |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address for a call (PC + 4) |

## Verification
On every cycle, the assertions check several rules against the decoder's kind: that a disabled PC holds, that sequential and not-taken branch steps add 4, that a register jump copies the register value, and that direct jumps keep the region bits and word alignment. Some results only the bench's scenarios can show. These are the exact branch targets, including backward and wrapping offsets, the spliced 26-bit jump field, the reset value, and `link_addr` after a call. The bench compares them against its own model over random and directed instruction streams.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned OPW  = 6;

    localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OP_JMP   = 6'd2;
    localparam logic [OPW-1:0] OP_CALL  = 6'd3;
    localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OP_BNE   = 6'd5;
    localparam logic [OPW-1:0] FN_JREG  = 6'd8;

    typedef enum logic [2:0] {
        KIND_SEQ,
        KIND_BEQ,
        KIND_BNE,
        KIND_JMP,
        KIND_CALL,
        KIND_JREG
    } pcu_kind_e;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic [OPW-1:0] funct,
    output pcu_kind_e      kind
);

    always_comb begin
        unique case (opcode)
            OP_BEQ:   kind = KIND_BEQ;
            OP_BNE:   kind = KIND_BNE;
            OP_JMP:   kind = KIND_JMP;
            OP_CALL:  kind = KIND_CALL;
            OP_RTYPE: kind = (funct == FN_JREG) ? KIND_JREG : KIND_SEQ;
            default:  kind = KIND_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_targets.sv
module pcu_targets
    import pcu_pkg::*;
#(
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned JFLD_W = 26
) (
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [JFLD_W-1:0] jfield,
    output logic [XLEN-1:0]   seq_addr,
    output logic [XLEN-1:0]   br_addr,
    output logic [XLEN-1:0]   jmp_addr
);

    localparam int unsigned EXT_W = XLEN - IMM_W - 2;
    localparam int unsigned HI_W  = XLEN - JFLD_W - 2;

    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  offset_bytes;

    assign imm          = jfield[IMM_W-1:0];
    assign offset_bytes = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};

    always_comb begin
        seq_addr = cur_pc + XLEN'(4);
        br_addr  = seq_addr + offset_bytes;
        jmp_addr = {cur_pc[XLEN-1 -: HI_W], jfield, 2'b00};
    end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic        cmp_eq,
    input  logic [31:0] reg_target,
    output logic [31:0] pc,
    output logic [31:0] link_addr
);

    pcu_kind_e   kind;
    logic [31:0] seq_addr;
    logic [31:0] br_addr;
    logic [31:0] jmp_addr;
    logic [31:0] next_pc;

    pcu_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .kind   (kind)
    );

    pcu_targets #(
        .IMM_W  (16),
        .JFLD_W (26)
    ) u_targets (
        .cur_pc   (pc),
        .jfield   (instr[25:0]),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    always_comb begin
        unique case (kind)
            KIND_BEQ:  next_pc = cmp_eq  ? br_addr : seq_addr;
            KIND_BNE:  next_pc = !cmp_eq ? br_addr : seq_addr;
            KIND_JMP,
            KIND_CALL: next_pc = jmp_addr;
            KIND_JREG: next_pc = reg_target;
            default:   next_pc = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     pc <= RESET_PC;
        else if (en) pc <= next_pc;
    end

    assign link_addr = seq_addr;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && kind == KIND_SEQ) |=> (pc == $past(pc) + 32'd4));

    // R4
    beq_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (en && kind == KIND_BEQ && !cmp_eq) |=> (pc == $past(pc) + 32'd4));

    // R5
    bne_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (en && kind == KIND_BNE && cmp_eq) |=> (pc == $past(pc) + 32'd4));

    // R7
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (kind == KIND_JMP || kind == KIND_CALL))
        |=> (pc[31:28] == $past(pc[31:28]) && pc[1:0] == 2'b00));

    // R9
    jreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (en && kind == KIND_JREG) |=> (pc == $past(reg_target)));

endmodule

// File: tb/tb_pc_next_unit.sv
`timescale 1ns/1ps
module tb_pc_next_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [31:0] instr;
    logic        cmp_eq;
    logic [31:0] reg_target;
    logic [31:0] pc;
    logic [31:0] link_addr;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic [31:0] exp_pc;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pc_next_unit dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .instr      (instr),
        .cmp_eq     (cmp_eq),
        .reg_target (reg_target),
        .pc         (pc),
        .link_addr  (link_addr)
    );

    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] ins,
                                               input logic eq, input logic [31:0] rv);
        logic [31:0] nxt;
        logic [31:0] off;
        nxt = cur + 32'd4;
        off = {{14{ins[15]}}, ins[15:0], 2'b00};
        case (ins[31:26])
            6'd4:    return eq  ? nxt + off : nxt;
            6'd5:    return !eq ? nxt + off : nxt;
            6'd2,
            6'd3:    return {cur[31:28], ins[25:0], 2'b00};
            6'd0:    return (ins[5:0] == 6'd8) ? rv : nxt;
            default: return nxt;
        endcase
    endfunction

    function automatic string tag_of(input logic e, input logic [31:0] ins);
        if (!e) return "R2";
        case (ins[31:26])
            6'd4:    return "R4";
            6'd5:    return "R5";
            6'd2:    return "R7";
            6'd3:    return "R8";
            6'd0:    return (ins[5:0] == 6'd8) ? "R9" : "R3";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic [31:0] ins, input logic eq,
                        input logic [31:0] rv, input string tag);
        logic [31:0] nx;
        en = e; instr = ins; cmp_eq = eq; reg_target = rv;
        nx = e ? model_next(exp_pc, ins, eq, rv) : exp_pc;
        @(negedge clk);
        exp_pc = nx;
        check(pc, exp_pc, tag);
        check(link_addr, exp_pc + 32'd4, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; en = 1'b1; instr = 32'h0; cmp_eq = 1'b0; reg_target = 32'hDEAD_BEE0;
        @(negedge clk);
        instr = 32'h0800_1234;
        @(negedge clk);
        exp_pc = 32'h0;
        check(pc, 32'h0, "R1");
        rst = 1'b0;

        step(1'b1, 32'h0000_0020, 1'b0, 32'h0, "R3");
        step(1'b1, 32'h0000_0009, 1'b0, 32'h0, "R3");
        step(1'b0, 32'h0800_00FF, 1'b0, 32'h0, "R2");
        step(1'b1, 32'h1000_0003, 1'b1, 32'h0, "R4");
        step(1'b1, 32'h1000_0003, 1'b0, 32'h0, "R4");
        step(1'b1, 32'h1400_0010, 1'b0, 32'h0, "R5");
        step(1'b1, 32'h1400_0010, 1'b1, 32'h0, "R5");
        step(1'b1, 32'h1000_FFFF, 1'b1, 32'h0, "R6");
        step(1'b1, 32'h1400_FFF0, 1'b0, 32'h0, "R6");
        step(1'b1, 32'h0000_0008, 1'b0, 32'hA000_0000, "R9");
        step(1'b1, 32'h0BFF_FFFF, 1'b0, 32'h0, "R7");
        check(pc, 32'hAFFF_FFFC, "R7");
        step(1'b1, 32'h0000_0008, 1'b0, 32'h5000_0100, "R9");
        step(1'b1, 32'h0C00_0040, 1'b0, 32'h0, "R8");
        check(link_addr, 32'h5000_0104, "R8");
        step(1'b1, 32'h0000_0008, 1'b0, 32'hFFFF_FFFC, "R9");
        check(link_addr, 32'h0, "R10");
        step(1'b1, 32'h0000_0000, 1'b0, 32'h0, "R6");
        check(pc, 32'h0, "R6");
        step(1'b1, 32'h1000_8000, 1'b1, 32'h0, "R6");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            logic        e;
            int unsigned pick;
            ins  = $urandom;
            pick = $urandom_range(0, 9);
            case (pick)
                0: ins[31:26] = 6'd4;
                1: ins[31:26] = 6'd5;
                2: ins[31:26] = 6'd2;
                3: ins[31:26] = 6'd3;
                4: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8; end
                5: ins[31:26] = 6'd0;
                default: ;
            endcase
            e = ($urandom_range(0, 7) != 0);
            step(e, ins, 1'($urandom_range(0, 1)), $urandom, tag_of(e, ins));
        end

        rst = 1'b1;
        en  = 1'b0;
        @(negedge clk);
        exp_pc = 32'h0;
        check(pc, 32'h0, "R1");
        rst = 1'b0;
        step(1'b1, 32'h2000_0000, 1'b0, 32'h0, "R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule